// File: doc/BRIEF.md
# March LR Memory Self-Test Engine

This engine tests a word-oriented synchronous RAM that has `2**ADDR_W` addresses and `DATA_W`-bit words. After a start request it drives the RAM port for one operation per cycle. First it applies a six-element march of solid all-zero and all-one words. It then applies one extra pass for each of the `log2(DATA_W)` striped backgrounds. In each background, bit groups of width 1, 2, 4 and so on alternate inside a word. These passes expose bridges and coupling between bits of the same word, which a solid word can never stimulate.

Every read is compared with its expected word in the cycle after the address is issued, which matches a RAM with one cycle of read latency. The first mismatch raises a sticky fail flag and freezes the failing address and element number. A run ends with done held high. The result stays visible until the next start request, which begins a new run and clears the previous outcome.

Top module: `mbist_march_lr`

## Requirements
- R1: During and right after reset, and after a reset applied mid-run, `busy_o`, `done_o`, `fail_o` and `mem_we_o` are low.
- R2: A start request sampled while idle or done begins a run. `busy_o` is high from the next cycle until the cycle in which `done_o` rises. A start request sampled while busy is ignored.
- R3: The solid part of the run uses "0" = all zeros and "1" = all ones. Each element runs all of its operations at one address before it moves to the next address. The elements are numbered 0 to 5:
  - 0: any order (w0)
  - 1: descending (r0,w1)
  - 2: ascending (r1,w0,r0,r0,w1)
  - 3: ascending (r1,w0)
  - 4: ascending (r0,w1,r1,r1,w0)
  - 5: any order (r0)
  
  The "any order" elements run ascending.
- R4: For j = 1..log2(DATA_W), element 5+j runs ascending with background D, where bit i of D equals bit j-1 of i. It applies wD, rD, w~D, r~D, r~D, wD, rD at each address.
- R5: A run issues exactly (16 + 7·log2(DATA_W))·N operations. `done_o` is first high in cycle ops+2 counted from the clock edge that samples start.
- R6: Read data is compared one cycle after its read address is issued. `mem_we_o` is high only in the cycles that issue writes.
- R7: Any read mismatch sets `fail_o`, which stays high until the next accepted start.
- R8: `fail_addr_o` and `fail_elem_o` hold the address and the element number (0 to 5+log2(DATA_W)) of the first mismatch of the run. Later mismatches do not change them.
- R9: `done_o` stays high until the next accepted start. That start clears `done_o` and `fail_o` in the following cycle.
- R10: A fault that bridges two bits of one word is found in the first background pass that drives those two bits to different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of first mismatch |
| fail_elem_o | output | ELEM_W | Element number of first mismatch |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after address |

## Verification
The bench builds the engine with `ADDR_W=3` and `DATA_W=4`. Eight addresses keep a full run at 240 operations, so every issued operation can be compared with an independently built trace. Four-bit words give two background passes, which makes a bridge between bits 0 and 1 (caught by the first stripe) and a bridge between bits 0 and 2 (missed by the first stripe, caught by the second) both reachable. Stuck-at and blocked-transition cells at chosen addresses then pin down the element and address of the first failure.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int SOLID_ELEMS = 6;

  typedef struct packed {
    logic wr;
    logic inv;
  } mop_t;

  localparam mop_t OP_R0 = 2'b00;
  localparam mop_t OP_R1 = 2'b01;
  localparam mop_t OP_W0 = 2'b10;
  localparam mop_t OP_W1 = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_FIN} seq_st_e;

  // index of the final operation inside element e
  function automatic logic [2:0] elem_last_op(input int e);
    case (e)
      0, 5:    return 3'd0;
      1, 3:    return 3'd1;
      2, 4:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  function automatic logic elem_down(input int e);
    return e == 1;
  endfunction

  // operation k of element e; inv=1 means the complemented background
  function automatic mop_t elem_op(input int e, input int k);
    mop_t m;
    m = OP_R0;
    case (e)
      0: m = OP_W0;
      1: m = (k == 0) ? OP_R0 : OP_W1;
      2: case (k)
           0:       m = OP_R1;
           1:       m = OP_W0;
           2, 3:    m = OP_R0;
           default: m = OP_W1;
         endcase
      3: m = (k == 0) ? OP_R1 : OP_W0;
      4: case (k)
           0:       m = OP_R0;
           1:       m = OP_W1;
           2, 3:    m = OP_R1;
           default: m = OP_W0;
         endcase
      5: m = OP_R0;
      default: case (k)
           0, 5:    m = OP_W0;
           1, 6:    m = OP_R0;
           2:       m = OP_W1;
           default: m = OP_R1;
         endcase
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              down_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [ADDR_W-1:0] addr_q;
  logic              down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      down_q <= down_i;
      addr_q <= down_i ? ADDR_MAX : '0;
    end else if (step_i) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = down_q ? (addr_q == '0) : (addr_q == ADDR_MAX);

  p_addr_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !down_q |=> addr_q == ADDR_W'($past(addr_q) + 1'b1))
    else $error("ascending step broken");

  p_addr_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && down_q |=> addr_q == ADDR_W'($past(addr_q) - 1'b1))
    else $error("descending step broken");

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o)
    else $error("address stepped past its end");

endmodule

// File: rtl/mbist_bg_gen.sv
module mbist_bg_gen #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BG_W   = 3
) (
  input  logic [BG_W-1:0]   bg_sel_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int NUM_BG = $clog2(DATA_W);

  logic [DATA_W-1:0] pat;

  // bg 0 is solid zero; bg j puts bit j-1 of the bit index into each bit
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic b;
    always_comb begin
      b = 1'b0;
      for (int j = 1; j <= NUM_BG; j++) begin
        if (int'(bg_sel_i) == j) b = ((gi >> (j - 1)) % 2) == 1;
      end
    end
    assign pat[gi] = b;
  end

  assign data_o = pat ^ {DATA_W{inv_i}};

endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ELEM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);

  logic              rd_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic              fail_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [ELEM_W-1:0] fail_elem_q;
  logic              miss;

  // align the expectation with read data that returns one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      rd_q   <= rd_i;
      exp_q  <= exp_i;
      addr_q <= addr_i;
      elem_q <= elem_i;
    end
  end

  assign miss = rd_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_elem_q <= '0;
    end else if (clr_i) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_elem_q <= '0;
    end else if (miss && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_q <= addr_q;
      fail_elem_q <= elem_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign fail_elem_o = fail_elem_q;

  p_miss_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q && (rdata_i != exp_q) && !clr_i |=> fail_o)
    else $error("mismatch not flagged");

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clr_i |=> fail_o)
    else $error("fail flag dropped");

  p_first_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clr_i |=> $stable(fail_addr_o) && $stable(fail_elem_o))
    else $error("first failure overwritten");

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned ELEM_W   = 4,
  parameter int unsigned BG_W     = 3,
  parameter int unsigned NUM_ELEM = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr_last_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              clr_o,
  output mop_t              op_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [BG_W-1:0]   bg_sel_o,
  output logic              addr_load_o,
  output logic              addr_down_o,
  output logic              addr_step_o
);

  seq_st_e           state_q;
  logic [ELEM_W-1:0] elem_q;
  logic [2:0]        opi_q;
  logic              start_ok, run, op_last, elem_last, adv_elem;

  assign run       = state_q == ST_RUN;
  assign start_ok  = start_i && (state_q == ST_IDLE || state_q == ST_FIN);
  assign op_last   = opi_q == elem_last_op(int'(elem_q));
  assign elem_last = elem_q == ELEM_W'(NUM_ELEM - 1);
  assign adv_elem  = run && op_last && addr_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      opi_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_FIN: begin
          if (start_i) begin
            state_q <= ST_RUN;
            elem_q  <= '0;
            opi_q   <= '0;
          end
        end
        ST_RUN: begin
          if (op_last) begin
            opi_q <= '0;
            if (addr_last_i) begin
              if (elem_last) state_q <= ST_DRAIN;
              else           elem_q  <= elem_q + 1'b1;
            end
          end else begin
            opi_q <= opi_q + 3'd1;
          end
        end
        default: state_q <= ST_FIN;  // drain: last compare completes
      endcase
    end
  end

  assign run_o       = run;
  assign busy_o      = run || state_q == ST_DRAIN;
  assign done_o      = state_q == ST_FIN;
  assign clr_o       = start_ok;
  assign op_o        = elem_op(int'(elem_q), int'(opi_q));
  assign elem_o      = elem_q;
  assign bg_sel_o    = (int'(elem_q) < SOLID_ELEMS) ? '0
                                                    : BG_W'(int'(elem_q) - (SOLID_ELEMS - 1));
  assign addr_load_o = start_ok || (adv_elem && !elem_last);
  assign addr_down_o = start_ok ? elem_down(0) : elem_down(int'(elem_q) + 1);
  assign addr_step_o = run && op_last && !addr_last_i;

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o)
    else $error("start not accepted");

  p_ignore_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && start_i && !adv_elem |=> run && $stable(elem_q))
    else $error("start disturbed a running pass");

  p_elem_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_elem && !elem_last |=> elem_q == ELEM_W'($past(elem_q) + 1'b1))
    else $error("element order broken");

  p_done_after_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |=> done_o && !busy_o)
    else $error("done late");

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o)
    else $error("done dropped");

endmodule

// File: rtl/mbist_march_lr.sv
module mbist_march_lr
  import mbist_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned NUM_BG   = $clog2(DATA_W),
  localparam int unsigned NUM_ELEM = SOLID_ELEMS + NUM_BG,
  localparam int unsigned ELEM_W   = $clog2(NUM_ELEM),
  localparam int unsigned BG_W     = $clog2(NUM_BG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic              run, clr, a_load, a_down, a_step, a_last;
  mop_t              op;
  logic [ELEM_W-1:0] elem;
  logic [BG_W-1:0]   bg_sel;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] pattern;

  mbist_seq #(
    .ELEM_W  (ELEM_W),
    .BG_W    (BG_W),
    .NUM_ELEM(NUM_ELEM)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .addr_last_i(a_last),
    .run_o      (run),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .clr_o      (clr),
    .op_o       (op),
    .elem_o     (elem),
    .bg_sel_o   (bg_sel),
    .addr_load_o(a_load),
    .addr_down_o(a_down),
    .addr_step_o(a_step)
  );

  mbist_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(a_load),
    .down_i(a_down),
    .step_i(a_step),
    .addr_o(addr),
    .last_o(a_last)
  );

  mbist_bg_gen #(.DATA_W(DATA_W), .BG_W(BG_W)) i_bg (
    .bg_sel_i(bg_sel),
    .inv_i   (op.inv),
    .data_o  (pattern)
  );

  mbist_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .rd_i       (run && !op.wr),
    .exp_i      (pattern),
    .addr_i     (addr),
    .elem_i     (elem),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o),
    .fail_elem_o(fail_elem_o)
  );

  assign mem_addr_o  = addr;
  assign mem_wdata_o = pattern;
  assign mem_we_o    = run && op.wr;

  p_we_in_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o && !done_o)
    else $error("write outside a run");

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o)
    else $error("write while idle");

endmodule

// File: tb/test_mbist_march_lr.sv
module test_mbist_march_lr;

  localparam int AW  = 3;
  localparam int DW  = 4;
  localparam int NB  = 2;
  localparam int N   = 8;
  localparam int NE  = 6 + NB;
  localparam int EW  = 3;
  localparam int OPS = (16 + 7 * NB) * N;

  // fault table: kind 0 none, 1 stuck0, 2 stuck1, 3 no 1->0 transition, 4 AND bridge b0/b1
  localparam int NV = 6;
  localparam int V_KIND [NV] = '{0, 1, 2, 3, 4, 4};
  localparam int V_ADDR [NV] = '{0, 5, 3, 4, 6, 1};
  localparam int V_B0   [NV] = '{0, 2, 0, 3, 0, 0};
  localparam int V_B1   [NV] = '{0, 0, 0, 0, 1, 2};
  localparam int V_FAIL [NV] = '{0, 1, 1, 1, 1, 1};
  localparam int V_ELEM [NV] = '{0, 2, 1, 2, 6, 7};
  localparam int V_FADR [NV] = '{0, 5, 3, 4, 6, 1};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, fail_o, mem_we_o;
  logic [AW-1:0] fail_addr_o, mem_addr_o;
  logic [EW-1:0] fail_elem_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] rdata = '0;
  logic [DW-1:0] mem [N];

  int n_chk = 0;
  int n_err = 0;
  int f_kind = 0, f_addr = 0, f_b0 = 0, f_b1 = 0;

  logic          exp_we [OPS];
  logic [AW-1:0] exp_a  [OPS];
  logic [DW-1:0] exp_d  [OPS];

  always #2 clk_i = ~clk_i;

  mbist_march_lr #(.ADDR_W(AW), .DATA_W(DW)) i_mbist_march_lr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o),
    .fail_elem_o(fail_elem_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .mem_rdata_i(rdata)
  );

  function automatic logic [DW-1:0] store(input logic [DW-1:0] old_v, input logic [DW-1:0] new_v,
                                          input int a);
    logic [DW-1:0] v;
    v = new_v;
    if (a == f_addr) begin
      case (f_kind)
        1: v[f_b0] = 1'b0;
        2: v[f_b0] = 1'b1;
        3: if (old_v[f_b0] && !new_v[f_b0]) v[f_b0] = 1'b1;
        4: begin
          v[f_b0] = new_v[f_b0] & new_v[f_b1];
          v[f_b1] = v[f_b0];
        end
        default: ;
      endcase
    end
    return v;
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= store(mem[mem_addr_o], mem_wdata_o, int'(mem_addr_o));
    rdata <= mem[mem_addr_o];
  end

  function automatic string el_str(input int e);
    case (e)
      0: return "w0";
      1: return "r0w1";
      2: return "r1w0r0r0w1";
      3: return "r1w0";
      4: return "r0w1r1r1w0";
      5: return "r0";
      default: return "w0r0w1r1r1w0r0";
    endcase
  endfunction

  function automatic logic [DW-1:0] bg_of(input int e);
    logic [DW-1:0] v;
    v = '0;
    if (e >= 6) for (int i = 0; i < DW; i++) v[i] = ((i >> (e - 6)) % 2) == 1;
    return v;
  endfunction

  task automatic build_trace();
    int idx;
    idx = 0;
    for (int e = 0; e < NE; e++) begin
      string s;
      s = el_str(e);
      for (int st = 0; st < N; st++) begin
        int a;
        a = (e == 1) ? N - 1 - st : st;
        for (int k = 0; k < s.len() / 2; k++) begin
          exp_we[idx] = s.getc(2 * k) == "w";
          exp_a[idx]  = AW'(a);
          exp_d[idx]  = (s.getc(2 * k + 1) == "1") ? ~bg_of(e) : bg_of(e);
          idx++;
        end
      end
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < N; i++) mem[i] = '0;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act,
                       input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_run(input int pulse_at, output int cycles, output int busy_err,
                        output int trace_err, output bit clr_ok);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    cycles = 0; busy_err = 0; trace_err = 0;
    clr_ok = !fail_o && !done_o;
    for (int k = 1; k <= OPS + 20; k++) begin
      if (done_o) begin
        cycles = k;
        break;
      end
      start_i = (k == pulse_at);
      if (!busy_o) busy_err++;
      if (k <= OPS) begin
        if (mem_we_o !== exp_we[k-1] || mem_addr_o !== exp_a[k-1] ||
            (exp_we[k-1] && mem_wdata_o !== exp_d[k-1])) trace_err++;
      end else if (mem_we_o) begin
        trace_err++;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc, berr, terr;
    bit clr;
    build_trace();
    clear_mem();
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o && !mem_we_o, "R1", "outputs in reset",
          int'({busy_o, done_o, fail_o, mem_we_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o && !mem_we_o, "R1", "outputs after reset",
          int'({busy_o, done_o, fail_o, mem_we_o}), 0);

    for (int v = 0; v < NV; v++) begin
      f_kind = V_KIND[v]; f_addr = V_ADDR[v]; f_b0 = V_B0[v]; f_b1 = V_B1[v];
      clear_mem();
      do_run(0, cyc, berr, terr, clr);
      check(cyc == OPS + 2, "R5", "done cycle", cyc, OPS + 2);
      check(berr == 0, "R2", "busy gaps", berr, 0);
      check(terr == 0, "R3 R4 R6", "operation trace mismatches", terr, 0);
      check(clr, "R9", "start clears done and fail", int'(clr), 1);
      check(fail_o == V_FAIL[v], "R7", "fail flag", int'(fail_o), V_FAIL[v]);
      if (V_FAIL[v] != 0) begin
        check(int'(fail_addr_o) == V_FADR[v], (V_KIND[v] == 4) ? "R10" : "R8",
              "first fail address", int'(fail_addr_o), V_FADR[v]);
        check(int'(fail_elem_o) == V_ELEM[v], (V_KIND[v] == 4) ? "R10" : "R8",
              "first fail element", int'(fail_elem_o), V_ELEM[v]);
      end
      repeat (3) @(negedge clk_i);
      check(done_o && !busy_o && fail_o == V_FAIL[v], "R9", "result held",
            int'({done_o, busy_o, fail_o}), int'({1'b1, 1'b0, V_FAIL[v] != 0}));
    end

    // start while busy is ignored
    f_kind = 0;
    clear_mem();
    do_run(50, cyc, berr, terr, clr);
    check(cyc == OPS + 2, "R2", "done cycle with start mid-run", cyc, OPS + 2);
    check(terr == 0 && !fail_o, "R2", "trace with start mid-run", terr, 0);

    // reset in the middle of a run
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o && !mem_we_o, "R1", "outputs after mid-run reset",
          int'({busy_o, done_o, fail_o, mem_we_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    f_kind = 1; f_addr = 5; f_b0 = 2;
    do_run(0, cyc, berr, terr, clr);
    check(cyc == OPS + 2 && fail_o && int'(fail_elem_o) == 2, "R7", "run after reset",
          int'(fail_elem_o), 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule